// File: doc/BRIEF.md
# Throttled DMA Minor-Loop Sequencer

This block runs the minor loop of a single DMA channel. A one-cycle start pulse loads a source pointer, a destination pointer, a byte count and a 2-bit throttle setting. The sequencer then moves one data word at a time. Each word is a read request on the read port, answered by a grant that carries the data, followed by a write request on the write port that carries the same word. Both pointers advance by the word size in bytes after their access. The loop stops once the remaining byte count is used up.

The throttle setting limits how often the channel asks the interconnect for the bus. Depending on its value, the sequencer waits 0, 4 or 8 idle cycles after every completed read and every completed write, and raises no request while it waits. The setting is captured when the loop starts. A busy flag is high while the loop runs. A one-cycle done pulse marks normal completion. An error input aborts the loop at once and answers with a one-cycle error pulse in place of done.

Top module: `dma_minor_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy_o`, `done_o`, `err_o`, `rd_req_o` and `wr_req_o` are all low.
- R2: Each transfer reads at the current source pointer and then writes the word it read to the current destination pointer. Both pointers start at the loaded values and each grows by DW/8 after its own handshake. A request stays high, with a stable address, until its grant arrives.
- R3: A loop with byte count n > 0 makes exactly ceil(n / (DW/8)) reads and ceil(n / (DW/8)) writes, and the remaining count falls at every write handshake.
- R4: Throttle value 2'b00 leaves zero idle cycles. The next request, or done, comes in the cycle right after a handshake.
- R5: Throttle value 2'b10 leaves exactly 4 cycles with no request after every read handshake and every write handshake, including the final write before done.
- R6: Throttle value 2'b11 leaves exactly 8 such cycles after every handshake.
- R7: Throttle value 2'b01 behaves exactly like 2'b00.
- R8: The throttle value is sampled in the start cycle. Changing `throttle_i` while the loop runs does not change the idle cycles of that loop.
- R9: `busy_o` goes high in the cycle after start. Once the last write handshake and its idle cycles are over, `done_o` is high for exactly one cycle, and `busy_o` is already low in that cycle.
- R10: If `err_i` is high while busy, then in the next cycle `err_o` pulses for one cycle, `busy_o` and both requests are low, and no further access or done follows for that loop. A grant that arrives in the same cycle as the error is not taken.
- R11: A start pulse that arrives while busy is ignored and does not change the addresses or the number of transfers of the running loop.
- R12: A start with byte count 0 makes no access, keeps `busy_o` low, and gives `done_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; loads pointers, count and throttle |
| src_addr_i | input | AW | First source address |
| dst_addr_i | input | AW | First destination address |
| nbytes_i | input | CW | Minor loop byte count |
| throttle_i | input | 2 | Idle-cycle setting: 00/01 none, 10 four, 11 eight |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_gnt_i | input | 1 | Read grant; data is valid with it |
| rd_data_i | input | DW | Read data |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data |
| wr_gnt_i | input | 1 | Write grant |
| err_i | input | 1 | Bus or channel error |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle abort pulse |

## Verification
Busy rises one cycle after the start edge. A request comes either one cycle or N+1 cycles after the previous handshake edge, where N is 0, 4 or 8. Done follows the final write edge after the same N+1 cycles, and the error pulse comes one cycle after the edge that samples `err_i`. The bench samples at the falling edge. It counts request-free cycles between each observed handshake and the next request or done, and compares the count with the throttle value loaded at start. A scoreboard queue, filled by the driver before the start pulse, supplies the address and data that each write must carry.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        THR_NONE  = 2'b00,
        THR_RSVD  = 2'b01,
        THR_SHORT = 2'b10,
        THR_LONG  = 2'b11
    } thr_code_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD,
        S_RSTALL,
        S_WR,
        S_WSTALL,
        S_FIN,
        S_ABORT
    } seq_state_e;

    typedef struct packed {
        logic load;
        logic rd_hs;
        logic wr_hs;
        logic stalling;
    } seq_ctl_t;

    function automatic int unsigned stall_len(input thr_code_e code,
                                              input int unsigned short_n,
                                              input int unsigned long_n);
        case (code)
            THR_SHORT: return short_n;
            THR_LONG:  return long_n;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/dma_seq_throttle.sv
module dma_seq_throttle
    import dma_seq_pkg::*;
#(
    parameter int STALL_SHORT = 4,
    parameter int STALL_LONG  = 8,
    localparam int SW = $clog2(STALL_LONG + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [1:0] code_i,
    input  logic       hs_i,
    input  logic       stalling_i,
    input  logic       busy_i,
    output logic       stall_nz_o,
    output logic       stall_end_o
);

    thr_code_e     code_q;
    logic [SW-1:0] len;
    logic [SW-1:0] cnt;

    assign len = SW'(stall_len(code_q, STALL_SHORT, STALL_LONG));

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= THR_NONE;
            cnt    <= '0;
        end else begin
            if (load_i) begin
                code_q <= thr_code_e'(code_i);
            end
            if (hs_i) begin
                cnt <= len;
            end else if (stalling_i && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign stall_nz_o  = (len != '0);
    assign stall_end_o = stalling_i && (cnt == SW'(1));

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        busy_i && $past(busy_i) |-> $stable(code_q)); // R8

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= SW'(STALL_LONG)); // R6

endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
    parameter int CW  = 16,
    parameter int BPX = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] nbytes_i,
    input  logic          wr_hs_i,
    output logic          last_o,
    output logic          empty_o
);

    logic [CW-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (load_i) begin
            rem <= nbytes_i;
        end else if (wr_hs_i) begin
            if (rem > CW'(BPX)) begin
                rem <= rem - CW'(BPX);
            end else begin
                rem <= '0;
            end
        end
    end

    assign last_o  = (rem <= CW'(BPX));
    assign empty_o = (rem == '0);

    AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        wr_hs_i |=> rem < $past(rem)); // R3

endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int BPX = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic          rd_hs_i,
    input  logic [DW-1:0] rd_data_i,
    input  logic          wr_hs_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);

    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            hold_q <= '0;
        end else if (load_i) begin
            src_q <= src_i;
            dst_q <= dst_i;
        end else begin
            if (rd_hs_i) begin
                src_q  <= src_q + AW'(BPX);
                hold_q <= rd_data_i;
            end
            if (wr_hs_i) begin
                dst_q <= dst_q + AW'(BPX);
            end
        end
    end

    assign rd_addr_o = src_q;
    assign wr_addr_o = dst_q;
    assign wr_data_o = hold_q;

    AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
        rd_hs_i |=> rd_addr_o == $past(rd_addr_o) + AW'(BPX)); // R2

    AST_DATA_KEPT: assert property (@(posedge clk) disable iff (rst)
        wr_hs_i |=> $stable(wr_data_o)); // R2

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     zero_i,
    input  logic     rd_gnt_i,
    input  logic     wr_gnt_i,
    input  logic     err_i,
    input  logic     stall_nz_i,
    input  logic     stall_end_i,
    input  logic     last_i,
    input  logic     empty_i,
    output seq_ctl_t ctl_o,
    output logic     rd_req_o,
    output logic     wr_req_o,
    output logic     busy_o,
    output logic     done_o,
    output logic     err_o
);

    seq_state_e state;
    seq_state_e nxt;
    logic       run_err;

    assign rd_req_o = (state == S_RD);
    assign wr_req_o = (state == S_WR);
    assign busy_o   = (state == S_RD) || (state == S_RSTALL) ||
                      (state == S_WR) || (state == S_WSTALL);
    assign done_o   = (state == S_FIN);
    assign err_o    = (state == S_ABORT);
    assign run_err  = busy_o && err_i;

    always_comb begin
        ctl_o.load     = (state == S_IDLE) && start_i;
        ctl_o.rd_hs    = rd_req_o && rd_gnt_i && !err_i;
        ctl_o.wr_hs    = wr_req_o && wr_gnt_i && !err_i;
        ctl_o.stalling = ((state == S_RSTALL) || (state == S_WSTALL)) && !err_i;
    end

    always_comb begin
        nxt = state;
        if (run_err) begin
            nxt = S_ABORT;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start_i) nxt = zero_i ? S_FIN : S_RD;
                end
                S_RD: begin
                    if (rd_gnt_i) nxt = stall_nz_i ? S_RSTALL : S_WR;
                end
                S_RSTALL: begin
                    if (stall_end_i) nxt = S_WR;
                end
                S_WR: begin
                    if (wr_gnt_i) begin
                        if (stall_nz_i) nxt = S_WSTALL;
                        else            nxt = last_i ? S_FIN : S_RD;
                    end
                end
                S_WSTALL: begin
                    if (stall_end_i) nxt = empty_i ? S_FIN : S_RD;
                end
                S_FIN:   nxt = S_IDLE;
                S_ABORT: nxt = S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && !rd_gnt_i && !err_i |=> rd_req_o); // R2

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_req_o && !wr_gnt_i && !err_i |=> wr_req_o); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o); // R9

    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (rst)
        busy_o && err_i |=> err_o && !busy_o && !done_o && !rd_req_o && !wr_req_o); // R10

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) && start_i && !zero_i |=> busy_o); // R9

endmodule

// File: rtl/dma_minor_seq.sv
module dma_minor_seq
    import dma_seq_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int CW          = 16,
    parameter int STALL_SHORT = 4,
    parameter int STALL_LONG  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] src_addr_i,
    input  logic [AW-1:0] dst_addr_i,
    input  logic [CW-1:0] nbytes_i,
    input  logic [1:0]    throttle_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_gnt_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_req_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_gnt_i,
    input  logic          err_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);

    localparam int BPX = DW / 8;

    seq_ctl_t ctl;
    logic     stall_nz;
    logic     stall_end;
    logic     last;
    logic     empty;
    logic     zero;

    assign zero = (nbytes_i == '0);

    dma_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .zero_i     (zero),
        .rd_gnt_i   (rd_gnt_i),
        .wr_gnt_i   (wr_gnt_i),
        .err_i      (err_i),
        .stall_nz_i (stall_nz),
        .stall_end_i(stall_end),
        .last_i     (last),
        .empty_i    (empty),
        .ctl_o      (ctl),
        .rd_req_o   (rd_req_o),
        .wr_req_o   (wr_req_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    dma_seq_throttle #(
        .STALL_SHORT(STALL_SHORT),
        .STALL_LONG (STALL_LONG)
    ) u_thr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ctl.load),
        .code_i     (throttle_i),
        .hs_i       (ctl.rd_hs || ctl.wr_hs),
        .stalling_i (ctl.stalling),
        .busy_i     (busy_o),
        .stall_nz_o (stall_nz),
        .stall_end_o(stall_end)
    );

    dma_seq_count #(
        .CW (CW),
        .BPX(BPX)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ctl.load),
        .nbytes_i(nbytes_i),
        .wr_hs_i (ctl.wr_hs),
        .last_o  (last),
        .empty_o (empty)
    );

    dma_seq_addr #(
        .AW (AW),
        .DW (DW),
        .BPX(BPX)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load_i   (ctl.load),
        .src_i    (src_addr_i),
        .dst_i    (dst_addr_i),
        .rd_hs_i  (ctl.rd_hs),
        .rd_data_i(rd_data_i),
        .wr_hs_i  (ctl.wr_hs),
        .rd_addr_o(rd_addr_o),
        .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o)
    );

    AST_THROTTLE_GAP: assert property (@(posedge clk) disable iff (rst)
        (ctl.rd_hs || ctl.wr_hs) && stall_nz |=> !rd_req_o && !wr_req_o); // R5

    AST_B2B_WRITE: assert property (@(posedge clk) disable iff (rst)
        ctl.rd_hs && !stall_nz |=> wr_req_o); // R4

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        !(rd_req_o && wr_req_o)); // R2

endmodule

// File: tb/tb_dma_minor_seq.sv
`timescale 1ns/1ps
module tb_dma_minor_seq;

    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int CW  = 16;
    localparam int BPX = DW / 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic [AW-1:0] src_addr_i;
    logic [AW-1:0] dst_addr_i;
    logic [CW-1:0] nbytes_i;
    logic [1:0]    throttle_i;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_gnt_i;
    logic [DW-1:0] rd_data_i;
    logic          wr_req_o;
    logic [AW-1:0] wr_addr_o;
    logic [DW-1:0] wr_data_o;
    logic          wr_gnt_i;
    logic          err_i;
    logic          busy_o;
    logic          done_o;
    logic          err_o;

    always #4 clk = ~clk;

    dma_minor_seq dut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .src_addr_i(src_addr_i),
        .dst_addr_i(dst_addr_i),
        .nbytes_i  (nbytes_i),
        .throttle_i(throttle_i),
        .rd_req_o  (rd_req_o),
        .rd_addr_o (rd_addr_o),
        .rd_gnt_i  (rd_gnt_i),
        .rd_data_i (rd_data_i),
        .wr_req_o  (wr_req_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .wr_gnt_i  (wr_gnt_i),
        .err_i     (err_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    assign rd_data_i = mem_word(rd_addr_o);

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } item_t;
    item_t exp_q[$];

    int    exp_gap   = 0;
    string gap_req   = "R4";
    bit    gap_armed = 1'b0;
    int    gap_cnt   = 0;
    int    rd_seen   = 0;
    int    wr_seen   = 0;
    int    done_seen = 0;
    int    err_seen  = 0;
    int    gcnt      = 0;

    // responder and monitor
    always @(negedge clk) begin
        gcnt++;
        rd_gnt_i = rd_req_o && (gcnt % 3 != 0) && !err_i;
        wr_gnt_i = wr_req_o && (gcnt % 3 != 1) && !err_i;
        if (!rst) begin
            if (done_o) done_seen++;
            if (err_o)  err_seen++;
            if (gap_armed) begin
                if (rd_req_o || wr_req_o || done_o) begin
                    chk(gap_cnt == exp_gap, gap_req, "idle cycles after handshake",
                        gap_cnt, exp_gap);
                    gap_armed = 1'b0;
                end else if (err_o) begin
                    gap_armed = 1'b0;
                end else begin
                    gap_cnt++;
                end
            end
            if (rd_req_o && rd_gnt_i) begin
                rd_seen++;
                gap_armed = 1'b1;
                gap_cnt   = 0;
            end
            if (wr_req_o && wr_gnt_i) begin
                wr_seen++;
                gap_armed = 1'b1;
                gap_cnt   = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected write", wr_addr_o, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(wr_addr_o == it.a, "R2", "write address", wr_addr_o, it.a);
                    chk(wr_data_o == it.d, "R2", "write data", wr_data_o, it.d);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic push_expected(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                                 input int n);
        int xfers;
        xfers = (n + BPX - 1) / BPX;
        for (int i = 0; i < xfers; i++) begin
            item_t it;
            it.a = dst + AW'(i * BPX);
            it.d = mem_word(src + AW'(i * BPX));
            exp_q.push_back(it);
        end
    endtask

    task automatic run_loop(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                            input int n, input logic [1:0] code,
                            input logic [1:0] code_mid, input bit poke,
                            input string greq);
        int xfers;
        int t;
        xfers   = (n + BPX - 1) / BPX;
        exp_gap = (code == 2'b10) ? 4 : (code == 2'b11) ? 8 : 0;
        gap_req = greq;
        push_expected(src, dst, n);
        rd_seen = 0; wr_seen = 0; done_seen = 0;
        @(posedge clk); #1;
        src_addr_i = src; dst_addr_i = dst; nbytes_i = CW'(n);
        throttle_i = code; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0; throttle_i = code_mid;
        @(negedge clk);
        chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
        if (poke) begin
            repeat (3) @(posedge clk);
            #1;
            src_addr_i = 32'h0000_9000; dst_addr_i = 32'h0000_A000;
            nbytes_i = CW'(8); start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!done_o && t < 4000);
        chk(done_o == 1'b1, "R9", "done seen", done_o, 1);
        chk(busy_o == 1'b0, "R9", "busy low with done", busy_o, 0);
        chk(wr_seen == xfers, "R3", "write count", wr_seen, xfers);
        chk(rd_seen == xfers, "R3", "read count", rd_seen, xfers);
        chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R9", "done is one cycle", done_o, 0);
        exp_q.delete();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int t;
        rst = 1'b1; start_i = 1'b0; err_i = 1'b0;
        src_addr_i = '0; dst_addr_i = '0; nbytes_i = '0; throttle_i = 2'b00;
        rd_gnt_i = 1'b0; wr_gnt_i = 1'b0;
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, err_o, rd_req_o, wr_req_o} == 5'b0, "R1",
            "outputs in reset", {busy_o, done_o, err_o, rd_req_o, wr_req_o}, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk({busy_o, done_o, err_o, rd_req_o, wr_req_o} == 5'b0, "R1",
            "outputs after reset", {busy_o, done_o, err_o, rd_req_o, wr_req_o}, 0);

        run_loop(32'h0000_1000, 32'h0000_2000, 20, 2'b00, 2'b00, 1'b0, "R4");
        run_loop(32'h0000_1100, 32'h0000_2200, 22, 2'b10, 2'b10, 1'b0, "R5");
        run_loop(32'h0000_1200, 32'h0000_2400, 12, 2'b11, 2'b11, 1'b0, "R6");
        run_loop(32'h0000_1300, 32'h0000_2600, 16, 2'b01, 2'b01, 1'b0, "R7");
        run_loop(32'h0000_1400, 32'h0000_2800, 16, 2'b10, 2'b00, 1'b0, "R8");
        run_loop(32'h0000_1500, 32'h0000_2A00, 16, 2'b00, 2'b00, 1'b1, "R11");

        // R12: zero byte count
        rd_seen = 0; wr_seen = 0;
        @(posedge clk); #1;
        nbytes_i = '0; start_i = 1'b1; throttle_i = 2'b11;
        @(posedge clk); #1;
        start_i = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b1, "R12", "done after zero start", done_o, 1);
        chk(busy_o == 1'b0, "R12", "busy stays low", busy_o, 0);
        @(negedge clk);
        chk(rd_seen + wr_seen == 0, "R12", "no access", rd_seen + wr_seen, 0);
        chk(done_o == 1'b0, "R12", "done one cycle", done_o, 0);

        // R10: error abort
        exp_gap = 0; gap_req = "R10";
        push_expected(32'h0000_3000, 32'h0000_4000, 64);
        rd_seen = 0; wr_seen = 0; done_seen = 0; err_seen = 0;
        @(posedge clk); #1;
        src_addr_i = 32'h0000_3000; dst_addr_i = 32'h0000_4000;
        nbytes_i = CW'(64); throttle_i = 2'b00; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        t = 0;
        while (wr_seen < 3 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        @(posedge clk); #1;
        err_i = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b1, "R10", "busy before error sampled", busy_o, 1);
        @(posedge clk); #1;
        err_i = 1'b0;
        @(negedge clk);
        chk(err_o == 1'b1, "R10", "error pulse", err_o, 1);
        chk(busy_o == 1'b0, "R10", "busy dropped", busy_o, 0);
        chk(rd_req_o == 1'b0 && wr_req_o == 1'b0, "R10", "requests dropped",
            {rd_req_o, wr_req_o}, 0);
        t = wr_seen;
        repeat (20) @(negedge clk);
        chk(wr_seen == t, "R10", "no writes after abort", wr_seen, t);
        chk(done_seen == 0, "R10", "no done after abort", done_seen, 0);
        chk(err_seen == 1, "R10", "error pulse one cycle", err_seen, 1);
        exp_q.delete();

        finish_run();
    end

endmodule